// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks the operands for the execute stage of a five-stage RISC-V integer pipeline. It compares the execute-stage source register numbers with the destination registers of the two older instructions, one in the memory stage and one in write-back. From that comparison it builds three select codes: one for ALU operand A, one for ALU operand B, and one for the store write-data path. It also applies each select to the candidate values: the register-file read, the memory-stage ALU result and the write-back data.

Operand B carries one extra rule. When the instruction takes an immediate, bits [24:20] of the instruction word hold immediate bits, not a register number. Operand B must then carry the immediate, even if those bits happen to equal a pending destination register. The store-data path reads the same rs2 field but ignores the immediate flag, because a store takes its base register plus offset through the ALU and still needs rs2 as write data.

All outputs are registered. They appear one clock after the inputs are presented, so that the block fits an FPGA timing budget. Stalling and the register file sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero on that edge.
- R2: Every select output uses 2'b00 for the register file, 2'b10 for the memory stage and 2'b01 for write-back. The value 2'b11 never appears. Outputs reflect the inputs sampled at the previous rising edge.
- R3: A stage counts as a match only when its write enable is high, its destination register is non-zero and its destination register equals the source register. Register x0 is never forwarded.
- R4: When the memory stage and the write-back stage both match the same source, the memory stage wins.
- R5: `opnd_a` equals the register-file rs1 value, the memory-stage result or the write-back data, according to `sel_a`.
- R6: When `ex_use_imm` is high, `imm_sel` is 1, `sel_b` is 2'b00 and `opnd_b` equals `ex_imm`, whatever the destination registers hold.
- R7: `sel_st` and `st_data` follow the rs2 match rules of R3 and R4 regardless of `ex_use_imm`.
- R8: When `ex_use_imm` is low, `imm_sel` is 0, `sel_b` equals `sel_st` and `opnd_b` equals `st_data`.
- R9: Consider a store whose base register is written by the instruction now in write-back, and whose data register is written by the instruction now in the memory stage. It gets `sel_a`=2'b01, `sel_st`=2'b10, and operand B set to the immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs1 | input | REG_AW | Execute-stage source register 1 number |
| ex_rs2 | input | REG_AW | Execute-stage source register 2 number |
| ex_use_imm | input | 1 | Execute-stage instruction takes an immediate as operand B |
| ex_imm | input | XLEN | Execute-stage immediate value |
| rf_rs1_val | input | XLEN | Register-file value read for rs1 |
| rf_rs2_val | input | XLEN | Register-file value read for rs2 |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_wr_en | input | 1 | Memory-stage register write enable |
| mem_alu_val | input | XLEN | Memory-stage ALU result |
| wb_rd | input | REG_AW | Write-back destination register |
| wb_wr_en | input | 1 | Write-back register write enable |
| wb_val | input | XLEN | Write-back data |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B forwarding select (2'b00 when immediate) |
| sel_st | output | 2 | Store-data source select |
| imm_sel | output | 1 | Operand B carries the immediate |
| opnd_a | output | XLEN | Selected operand A |
| opnd_b | output | XLEN | Selected operand B |
| st_data | output | XLEN | Selected store write data |

## Verification
The assertions check these rules on every cycle:
- the select encoding is legal;
- x0 and disabled writers never cause forwarding;
- the memory stage wins when both stages match;
- the immediate overrides operand B;
- the store path ignores the immediate flag;
- operand A and the store data carry the value their select names.

Seeded random stimulus draws register numbers from a narrow range so that matches and double matches come up often. It checks every output against bench reference functions. A few directed cases are also run:
- a store fed from both later stages;
- an immediate whose bits alias a pending destination;
- the reset values.

These directed cases show whole-scenario behaviour.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output fwd_src_e          sel
);
  logic mem_hit, wb_hit;

  // R3: a writer counts only if enabled and not targeting x0
  assign mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
  assign wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);

  // R4: the newer result (memory stage) takes precedence
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_src_e        sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] mem_val,
  input  logic [XLEN-1:0] wb_val,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (sel)
      SRC_MEM: y = mem_val;
      SRC_WB:  y = wb_val;
      default: y = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic              ex_use_imm,
  input  logic [XLEN-1:0]   ex_imm,
  input  logic [XLEN-1:0]   rf_rs1_val,
  input  logic [XLEN-1:0]   rf_rs2_val,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr_en,
  input  logic [XLEN-1:0]   mem_alu_val,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr_en,
  input  logic [XLEN-1:0]   wb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [1:0]        sel_st,
  output logic              imm_sel,
  output logic [XLEN-1:0]   opnd_a,
  output logic [XLEN-1:0]   opnd_b,
  output logic [XLEN-1:0]   st_data
);
  localparam int NSRC = 2;

  logic [REG_AW-1:0] src_num  [NSRC];
  logic [XLEN-1:0]   src_rf   [NSRC];
  fwd_src_e          src_sel  [NSRC];
  logic [XLEN-1:0]   src_fwd  [NSRC];

  assign src_num[0] = ex_rs1;
  assign src_num[1] = ex_rs2;
  assign src_rf[0]  = rf_rs1_val;
  assign src_rf[1]  = rf_rs2_val;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fwd_select #(.REG_AW(REG_AW)) u_sel (
      .src    (src_num[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_wr_en),
      .wb_rd  (wb_rd),
      .wb_we  (wb_wr_en),
      .sel    (src_sel[g])
    );
    fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel     (src_sel[g]),
      .rf_val  (src_rf[g]),
      .mem_val (mem_alu_val),
      .wb_val  (wb_val),
      .y       (src_fwd[g])
    );
  end

  // Operand B: immediate override applied after forwarding (R6, R8)
  logic [1:0]      sel_b_d;
  logic [XLEN-1:0] opnd_b_d;
  assign sel_b_d  = ex_use_imm ? SRC_RF : src_sel[1];
  assign opnd_b_d = ex_use_imm ? ex_imm : src_fwd[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a   <= '0;
      sel_b   <= '0;
      sel_st  <= '0;
      imm_sel <= 1'b0;
      opnd_a  <= '0;
      opnd_b  <= '0;
      st_data <= '0;
    end else begin
      sel_a   <= src_sel[0];
      sel_b   <= sel_b_d;
      sel_st  <= src_sel[1];   // R7: store path never sees the immediate flag
      imm_sel <= ex_use_imm;
      opnd_a  <= src_fwd[0];
      opnd_b  <= opnd_b_d;
      st_data <= src_fwd[1];
    end
  end
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rs2,
  input logic              ex_use_imm,
  input logic [XLEN-1:0]   ex_imm,
  input logic [XLEN-1:0]   rf_rs1_val,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wr_en,
  input logic [XLEN-1:0]   mem_alu_val,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_wr_en,
  input logic [XLEN-1:0]   wb_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [1:0]        sel_st,
  input logic              imm_sel,
  input logic [XLEN-1:0]   opnd_a,
  input logic [XLEN-1:0]   opnd_b,
  input logic [XLEN-1:0]   st_data
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  p_sel_legal_r2: assert property (@(posedge clk) disable iff (rst)
    primed |-> (sel_a != 2'b11 && sel_b != 2'b11 && sel_st != 2'b11));

  p_x0_never_r3: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(ex_rs1) == '0) |-> sel_a == 2'b00);

  p_mem_first_r4: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(mem_wr_en) && $past(mem_rd) != '0 && $past(mem_rd) == $past(ex_rs1))
      |-> sel_a == 2'b10);

  p_opa_value_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && sel_a == 2'b10) |-> opnd_a == $past(mem_alu_val));

  p_opa_rf_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && sel_a == 2'b00) |-> opnd_a == $past(rf_rs1_val));

  p_imm_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(ex_use_imm)) |-> (imm_sel && sel_b == 2'b00 && opnd_b == $past(ex_imm)));

  p_store_plain_r7: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(mem_wr_en) && $past(mem_rd) != '0 && $past(mem_rd) == $past(ex_rs2))
      |-> sel_st == 2'b10);

  p_store_wb_r7: assert property (@(posedge clk) disable iff (rst)
    (primed && sel_st == 2'b01) |-> st_data == $past(wb_val));

  p_b_tracks_store_r8: assert property (@(posedge clk) disable iff (rst)
    (primed && !imm_sel) |-> (sel_b == sel_st && opnd_b == st_data));
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
  .ex_use_imm(ex_use_imm), .ex_imm(ex_imm), .rf_rs1_val(rf_rs1_val),
  .mem_rd(mem_rd), .mem_wr_en(mem_wr_en), .mem_alu_val(mem_alu_val),
  .wb_rd(wb_rd), .wb_wr_en(wb_wr_en), .wb_val(wb_val),
  .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st), .imm_sel(imm_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .st_data(st_data)
);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic [REG_AW-1:0] ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic              ex_use_imm, mem_wr_en, wb_wr_en;
  logic [XLEN-1:0]   ex_imm, rf_rs1_val, rf_rs2_val, mem_alu_val, wb_val;
  logic [1:0]        sel_a, sel_b, sel_st;
  logic              imm_sel;
  logic [XLEN-1:0]   opnd_a, opnd_b, st_data;

  fwd_unit #(.XLEN(XLEN), .REG_AW(REG_AW)) dut (
    .clk(clk), .rst(rst), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_use_imm(ex_use_imm), .ex_imm(ex_imm), .rf_rs1_val(rf_rs1_val),
    .rf_rs2_val(rf_rs2_val), .mem_rd(mem_rd), .mem_wr_en(mem_wr_en),
    .mem_alu_val(mem_alu_val), .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .wb_val(wb_val), .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
    .imm_sel(imm_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .st_data(st_data)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference rules, written from the requirements (R3, R4)
  function automatic logic [1:0] ref_sel(input logic [REG_AW-1:0] s);
    if (mem_wr_en && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_wr_en && wb_rd != 0 && wb_rd == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] ref_val(input logic [1:0] s, input logic [XLEN-1:0] rf);
    if (s == 2'b10) return mem_alu_val;
    if (s == 2'b01) return wb_val;
    return rf;
  endfunction

  task automatic check_outputs(input string tag);
    logic [1:0] ea, es;
    ea = ref_sel(ex_rs1);
    es = ref_sel(ex_rs2);
    chk(tag, "sel_a R4", {30'b0, sel_a}, {30'b0, ea});
    chk(tag, "opnd_a R5", opnd_a, ref_val(ea, rf_rs1_val));
    chk(tag, "sel_st R7", {30'b0, sel_st}, {30'b0, es});
    chk(tag, "st_data R7", st_data, ref_val(es, rf_rs2_val));
    if (ex_use_imm) begin
      chk(tag, "imm_sel R6", {31'b0, imm_sel}, 32'd1);
      chk(tag, "sel_b R6", {30'b0, sel_b}, 32'd0);
      chk(tag, "opnd_b R6", opnd_b, ex_imm);
    end else begin
      chk(tag, "imm_sel R8", {31'b0, imm_sel}, 32'd0);
      chk(tag, "sel_b R8", {30'b0, sel_b}, {30'b0, es});
      chk(tag, "opnd_b R8", opnd_b, ref_val(es, rf_rs2_val));
    end
  endtask

  // Inputs change at the falling edge; outputs are sampled one full cycle later (R2)
  task automatic apply_and_check(input string tag);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic randomize_inputs();
    ex_rs1      = REG_AW'($urandom_range(0, 5));
    ex_rs2      = REG_AW'($urandom_range(0, 5));
    mem_rd      = REG_AW'($urandom_range(0, 5));
    wb_rd       = REG_AW'($urandom_range(0, 5));
    mem_wr_en   = 1'($urandom);
    wb_wr_en    = 1'($urandom);
    ex_use_imm  = 1'($urandom);
    ex_imm      = $urandom;
    rf_rs1_val  = $urandom;
    rf_rs2_val  = $urandom;
    mem_alu_val = $urandom;
    wb_val      = $urandom;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst = 1'b1;
    ex_rs1 = 5'd3; ex_rs2 = 5'd3; mem_rd = 5'd3; wb_rd = 5'd3;
    mem_wr_en = 1'b1; wb_wr_en = 1'b1; ex_use_imm = 1'b1;
    ex_imm = 32'h1111; rf_rs1_val = 32'h2222; rf_rs2_val = 32'h3333;
    mem_alu_val = 32'h4444; wb_val = 32'h5555;
    repeat (3) @(negedge clk);
    // R1: everything cleared while reset is held
    chk("R1", "sel_a", {30'b0, sel_a}, 32'd0);
    chk("R1", "sel_b", {30'b0, sel_b}, 32'd0);
    chk("R1", "sel_st", {30'b0, sel_st}, 32'd0);
    chk("R1", "imm_sel", {31'b0, imm_sel}, 32'd0);
    chk("R1", "opnd_a", opnd_a, 32'd0);
    chk("R1", "opnd_b", opnd_b, 32'd0);
    chk("R1", "st_data", st_data, 32'd0);
    rst = 1'b0;

    // R3: x0 destination is never forwarded
    ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; wb_rd = 0; ex_use_imm = 0;
    apply_and_check("R3 x0");
    chk("R3", "sel_a x0", {30'b0, sel_a}, 32'd0);

    // R3: disabled writers are ignored
    ex_rs1 = 4; ex_rs2 = 4; mem_rd = 4; wb_rd = 4; mem_wr_en = 0; wb_wr_en = 0;
    apply_and_check("R3 wen");
    chk("R3", "sel_st no wen", {30'b0, sel_st}, 32'd0);

    // R4: both stages write same register, memory stage wins
    mem_wr_en = 1; wb_wr_en = 1;
    apply_and_check("R4 both");
    chk("R4", "sel_a both", {30'b0, sel_a}, 32'd2);
    chk("R4", "opnd_a both", opnd_a, mem_alu_val);

    // R6/R7: immediate aliases a pending rd; operand B keeps immediate, store forwards
    ex_use_imm = 1; ex_rs2 = 2; mem_rd = 2; ex_imm = 32'h0000_0002; ex_rs1 = 1; wb_rd = 6;
    apply_and_check("R6 alias");
    chk("R6", "opnd_b alias", opnd_b, 32'h0000_0002);
    chk("R7", "sel_st alias", {30'b0, sel_st}, 32'd2);

    // R9: store, base from write-back, data from memory stage
    ex_rs1 = 7; wb_rd = 7; wb_wr_en = 1; ex_rs2 = 8; mem_rd = 8; mem_wr_en = 1;
    ex_use_imm = 1; ex_imm = 32'hFFFF_FFFC;
    apply_and_check("R9 store");
    chk("R9", "sel_a store", {30'b0, sel_a}, 32'd1);
    chk("R9", "sel_st store", {30'b0, sel_st}, 32'd2);
    chk("R9", "opnd_b store", opnd_b, 32'hFFFF_FFFC);
    chk("R9", "st_data store", st_data, mem_alu_val);

    // Random mix covering R2..R8
    for (int i = 0; i < 400; i++) begin
      randomize_inputs();
      apply_and_check("R2 rand");
    end

    // R1 again: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "opnd_a rerst", opnd_a, 32'd0);
    chk("R1", "sel_st rerst", {30'b0, sel_st}, 32'd0);
    rst = 1'b0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule